// File: doc/BRIEF.md
# Latched Bidirectional Parity Transceiver

This block moves a 9-bit word (eight data bits plus one parity bit) between two ports, A and B, in either direction. Each side has a level-sensitive latch. When its enable is high the latch is transparent. When the enable is low the latch holds its last word. A mode input chooses the parity of the outgoing word. In generate mode a freshly computed parity bit replaces the incoming one. In feed-through mode the received word passes unchanged, including its parity bit.

Each side checks its own latched word and reports a mismatch on an active-low error flag. Checking stays active in both modes. When one side drives, the outgoing word is captured back into that side's latch, so both flags can be valid at the same moment. The bus pins are modelled as separate input, output and output-enable ports. Every path from the latches to the outputs is combinational, and the block has no clock.

Top module: `ptx_transceiver`

## Requirements
- R1: With `gab_n` low and `gba_n` high, only `b_oe` is high. With `gba_n` low and `gab_n` high, only `a_oe` is high. With both enables high, neither output enable is high.
- R2: With both `gab_n` and `gba_n` low, neither output enable is high and `cfg_illegal` is high. In every other combination `cfg_illegal` is low.
- R3: When `mode_ft` is high, the driven word equals the source side's input-latch word in all nine bits. Bits 7:0 are data and bit 8 is parity.
- R4: When `mode_ft` is low, the driven word carries the source side's latched data in bits 7:0. Its bit 8 is the XOR of those eight bits, XORed with `odd_sel`: 0 gives even parity, 1 gives odd parity.
- R5: A side's latches follow their inputs while that side's latch enable is high. They hold their last value while the enable is low, and input changes then have no effect on the outputs.
- R6: A side's error flag is low exactly when the XOR of its checked word's data bits, XORed with `odd_sel`, differs from that word's bit 8. This holds in both modes.
- R7: While its latch enable is high, each side captures both its port input and the word the block computes for driving out of that side. A side that is driving checks the outgoing capture. A side that is not driving checks the input capture.
- R8: Output words are defined only while the matching output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 9 | Word seen on port A (bit 8 parity) |
| b_in | input | 9 | Word seen on port B (bit 8 parity) |
| gab_n | input | 1 | Active-low enable: drive port B from the A path |
| gba_n | input | 1 | Active-low enable: drive port A from the B path |
| mode_ft | input | 1 | 1 = feed-through, 0 = generate parity |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| le_a | input | 1 | A-side latch enable, high = transparent |
| le_b | input | 1 | B-side latch enable, high = transparent |
| a_out | output | 9 | Word driven onto port A |
| a_oe | output | 1 | Port A output enable |
| b_out | output | 9 | Word driven onto port B |
| b_oe | output | 1 | Port B output enable |
| err_a_n | output | 1 | A-side parity error, active low |
| err_b_n | output | 1 | B-side parity error, active low |
| cfg_illegal | output | 1 | Both drive enables asserted together |

## Verification
The assertions check the following at every evaluation:
- the output enables are decoded correctly and never both active;
- the illegal combination leaves both ports quiet;
- a generated word always carries correct parity;
- a transparent feed-through path copies the input exactly;
- a generated word looped back through an open destination latch never raises an error.

Only the bench's sequences can show the stateful behaviour. This covers words held while a latch is closed and input changes ignored during the hold. It also covers a corrupted word flagged on both sides at once in feed-through, and which capture a side checks after its drive direction changes.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_TO_B = 2'b01,
    DRV_TO_A = 2'b10,
    DRV_BOTH = 2'b11
  } drive_e;

  function automatic drive_e decode_drive(input logic gab_n, input logic gba_n);
    drive_e d;
    unique case ({gba_n, gab_n})
      2'b11:   d = DRV_NONE;
      2'b10:   d = DRV_TO_B;
      2'b01:   d = DRV_TO_A;
      default: d = DRV_BOTH;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ptx_latch.sv
module ptx_latch #(
  parameter int W = 9
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (en) q <= d;
  end
endmodule

// File: rtl/ptx_dir_path.sv
module ptx_dir_path #(
  parameter int DW = 8
) (
  input  logic [DW:0] src_word,
  input  logic        feed_thru,
  input  logic        odd_sel,
  output logic [DW:0] out_word
);
  logic gen_par;

  always_comb begin
    gen_par = (^src_word[DW-1:0]) ^ odd_sel;
    if (feed_thru) out_word = src_word;
    else           out_word = {gen_par, src_word[DW-1:0]};
  end
endmodule

// File: rtl/ptx_par_check.sv
module ptx_par_check #(
  parameter int DW = 8
) (
  input  logic [DW:0] word,
  input  logic        odd_sel,
  output logic        err_n
);
  logic calc;

  always_comb begin
    calc  = (^word[DW-1:0]) ^ odd_sel;
    err_n = (calc == word[DW]);
  end
endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W:0] a_in,
  input  logic [DATA_W:0] b_in,
  input  logic            gab_n,
  input  logic            gba_n,
  input  logic            mode_ft,
  input  logic            odd_sel,
  input  logic            le_a,
  input  logic            le_b,
  output logic [DATA_W:0] a_out,
  output logic            a_oe,
  output logic [DATA_W:0] b_out,
  output logic            b_oe,
  output logic            err_a_n,
  output logic            err_b_n,
  output logic            cfg_illegal
);
  import ptx_pkg::*;

  localparam int WW    = DATA_W + 1;
  localparam int SIDES = 2;

  drive_e drv;

  always_comb begin
    drv         = decode_drive(gab_n, gba_n);
    b_oe        = (drv == DRV_TO_B);
    a_oe        = (drv == DRV_TO_A);
    cfg_illegal = (drv == DRV_BOTH);
  end

  // index 0 = side A, index 1 = side B
  logic [SIDES-1:0][WW-1:0] port_q;
  logic [SIDES-1:0][WW-1:0] fb_q;
  logic [SIDES-1:0][WW-1:0] out_w;
  logic [SIDES-1:0][WW-1:0] chk_w;
  logic [SIDES-1:0][WW-1:0] pin_w;
  logic [SIDES-1:0]         le_v;
  logic [SIDES-1:0]         drv_v;
  logic [SIDES-1:0]         err_v;

  always_comb begin
    pin_w[0] = a_in;
    pin_w[1] = b_in;
    le_v     = {le_b, le_a};
    drv_v    = {b_oe, a_oe};
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    // input capture for this side
    ptx_latch #(.W(WW)) u_port_lat (
      .en (le_v[s]),
      .d  (pin_w[s]),
      .q  (port_q[s])
    );

    // outgoing word for this side is built from the opposite input capture
    ptx_dir_path #(.DW(DATA_W)) u_path (
      .src_word  (port_q[SIDES-1-s]),
      .feed_thru (mode_ft),
      .odd_sel   (odd_sel),
      .out_word  (out_w[s])
    );

    // loopback capture of the outgoing word
    ptx_latch #(.W(WW)) u_fb_lat (
      .en (le_v[s]),
      .d  (out_w[s]),
      .q  (fb_q[s])
    );

    always_comb begin
      chk_w[s] = drv_v[s] ? fb_q[s] : port_q[s];
    end

    ptx_par_check #(.DW(DATA_W)) u_chk (
      .word    (chk_w[s]),
      .odd_sel (odd_sel),
      .err_n   (err_v[s])
    );
  end

  always_comb begin
    a_out   = out_w[0];
    b_out   = out_w[1];
    err_a_n = err_v[0];
    err_b_n = err_v[1];
  end
endmodule

// File: rtl/ptx_transceiver_chk.sv
module ptx_transceiver_chk #(
  parameter int DW = 8
) (
  input logic [DW:0] a_in,
  input logic [DW:0] b_in,
  input logic        gab_n,
  input logic        gba_n,
  input logic        mode_ft,
  input logic        odd_sel,
  input logic        le_a,
  input logic        le_b,
  input logic [DW:0] a_out,
  input logic        a_oe,
  input logic [DW:0] b_out,
  input logic        b_oe,
  input logic        err_a_n,
  input logic        err_b_n,
  input logic        cfg_illegal
);
  always_comb begin
    p_b_drive_r1: assert (b_oe == (!gab_n && gba_n));
    p_a_drive_r1: assert (a_oe == (!gba_n && gab_n));
    p_oe_excl_r2: assert (!(a_oe && b_oe));
    p_illegal_quiet_r2: assert (!cfg_illegal || (!a_oe && !b_oe && !gab_n && !gba_n));
    p_ft_pass_r3: assert (!(mode_ft && b_oe && le_a) || (b_out == a_in));
    p_gen_par_b_r4: assert (mode_ft || !b_oe || (b_out[DW] == ((^b_out[DW-1:0]) ^ odd_sel)));
    p_gen_par_a_r4: assert (mode_ft || !a_oe || (a_out[DW] == ((^a_out[DW-1:0]) ^ odd_sel)));
    p_loop_clean_r7: assert (mode_ft || !b_oe || !le_b || err_b_n);
  end
endmodule

bind ptx_transceiver ptx_transceiver_chk #(.DW(DATA_W)) u_chk_bind (.*);

// File: tb/ptx_transceiver_tb.sv
module ptx_transceiver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int WATCHDOG   = 100000;

  logic          clk;
  logic [DW:0]   a_in, b_in, a_out, b_out;
  logic          gab_n, gba_n, mode_ft, odd_sel, le_a, le_b;
  logic          a_oe, b_oe, err_a_n, err_b_n, cfg_illegal;

  int total, bad, cyc;
  bit done;

  // model state
  logic [DW:0] m_pa, m_pb, m_fa, m_fb;

  ptx_transceiver #(.DATA_W(DW)) u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic pbit(input logic [DW-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [DW:0] route(input logic [DW:0] src, input logic ft, input logic odd);
    return ft ? src : {pbit(src[DW-1:0], odd), src[DW-1:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [DW:0] oa, ob, wa, wb;
    logic ea, eb, xa, xb;
    #(CLK_PERIOD/2);
    if (le_a) m_pa = a_in;
    if (le_b) m_pb = b_in;
    oa = route(m_pb, mode_ft, odd_sel);
    ob = route(m_pa, mode_ft, odd_sel);
    if (le_a) m_fa = oa;
    if (le_b) m_fb = ob;
    xa = !gba_n && gab_n;
    xb = !gab_n && gba_n;
    wa = xa ? m_fa : m_pa;
    wb = xb ? m_fb : m_pb;
    ea = (pbit(wa[DW-1:0], odd_sel) == wa[DW]);
    eb = (pbit(wb[DW-1:0], odd_sel) == wb[DW]);
    chk(a_oe == xa && b_oe == xb, "R1 oe", {7'd0, a_oe, b_oe}, {7'd0, xa, xb});
    chk(cfg_illegal == (!gab_n && !gba_n), "R2 illegal", {8'd0, cfg_illegal}, {8'd0, !gab_n && !gba_n});
    if (xb) chk(b_out == ob, mode_ft ? "R3 b_out" : "R4 b_out", b_out, ob);
    if (xa) chk(a_out == oa, mode_ft ? "R3 a_out" : "R4 a_out", a_out, oa);
    chk(err_a_n == ea, "R6/R7 err_a_n", {8'd0, err_a_n}, {8'd0, ea});
    chk(err_b_n == eb, "R6/R7 err_b_n", {8'd0, err_b_n}, {8'd0, eb});
    #(CLK_PERIOD/2);
  endtask

  task automatic setv(input logic [DW:0] a, input logic [DW:0] b, input logic gab, input logic gba,
                      input logic ft, input logic od, input logic la, input logic lb);
    a_in = a; b_in = b; gab_n = gab; gba_n = gba;
    mode_ft = ft; odd_sel = od; le_a = la; le_b = lb;
    step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!done && cyc > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    total = 0; bad = 0; cyc = 0; done = 0;
    seed = $urandom(32'h1d5);
    // R1 starting state: both ports as inputs, latches open
    setv(9'h000, 9'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(!a_oe && !b_oe, "R1 idle quiet", {7'd0, a_oe, b_oe}, 9'd0);
    // R4 even parity generated A->B with loopback, R7 both flags clean
    setv(9'h0_07, 9'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(b_out == 9'h1_07, "R4 even gen", b_out, 9'h1_07);
    chk(err_b_n == 1'b1, "R7 loopback clean", {8'd0, err_b_n}, 9'd1);
    // R4 odd parity
    setv(9'h0_07, 9'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    chk(b_out == 9'h0_07, "R4 odd gen", b_out, 9'h0_07);
    // R3/R6 feed-through of a corrupted word: both flags low
    setv(9'h0_01, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(b_out == 9'h0_01, "R3 passthru", b_out, 9'h0_01);
    chk(!err_a_n && !err_b_n, "R6 both flag", {7'd0, err_a_n, err_b_n}, 9'd0);
    // R5 hold: close A latch, change input, output unchanged
    setv(9'h0_01, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    setv(9'h1_F0, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(b_out == 9'h0_01, "R5 hold", b_out, 9'h0_01);
    // R2 illegal combination
    setv(9'h0AA, 9'h155, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(cfg_illegal && !a_oe && !b_oe, "R2 both low", {6'd0, cfg_illegal, a_oe, b_oe}, 9'b100);
    // B->A generate, R8 outputs only checked when enabled
    setv(9'h000, 9'h0_03, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(a_oe && a_out == 9'h0_03, "R8 a drive", a_out, 9'h0_03);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      setv(9'($urandom), 9'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule